// File: doc/BRIEF.md
# Bus Target Data-Phase Engine

This block is the responding side of a 32-bit multiplexed address/data bus of the PCI kind, serving a small word-addressed register store. It watches the master's transaction framing and ready strobes, decodes whether an address phase falls inside its window, and then drives the target handshake strobes: device select, target ready and stop. It also drives read data and its parity. All target-driven lines come as a value plus an output enable, so a pad ring or bus model can build the tristate drivers.

Writes complete with no wait state and update only the bytes whose enable is active. Reads add one turnaround clock before the data lines are driven. A data phase moves data only on a clock edge where the initiator-ready and target-ready strobes are both low. Bursts walk linearly through the store. When a burst reaches the last word, the block disconnects the master with stop. After the final phase, the strobes are driven high for one clock and then released.

Top module: `bus_target_ctrl`

## Requirements
- R1: While `rst` is high, every output enable (`ad_oe`, `trdy_oe`, `stop_oe`, `devsel_oe`, `par_oe`) is low in that same cycle. After reset they stay low until a decoded transaction starts.
- R2: An address phase is the first clock with `frame_n` low after a clock with it high. It is claimed only when the command is memory read (`cbe_n`=4'b0110) or memory write (4'b0111), `ad_in[31:WORD_AW+2]` equals the same bits of `BASE_ADDR`, and `ad_in[1:0]`=2'b00. Otherwise no strobe is driven and the store is unchanged.
- R3: On a claimed write, `devsel_n` and `trdy_n` are driven low one clock after the address phase. A phase completes on an edge with `irdy_n` and `trdy_n` both low. Only bytes whose `cbe_n` bit is 0 are written (bit k covers `ad_in[8k+7:8k]`).
- R4: On a claimed read, the clock after the address phase drives `devsel_n` low and `trdy_n` high with `ad_oe` low (turnaround). The next clock drives the addressed word on `ad_out` with `ad_oe` high and `trdy_n` low.
- R5: While `irdy_n` is high during a data phase, nothing completes. Read data on `ad_out` stays stable and the word index does not advance.
- R6: Each completed phase of a burst with `frame_n` still low advances to the next word. A read presents the next word in the clock after the completing edge, with no wait state.
- R7: When a phase completes with `frame_n` high, the next clock drives `trdy_n`, `stop_n` and `devsel_n` high with their enables set and `ad_oe` low. The clock after that releases all enables.
- R8: The phase serving the last word (index 2^WORD_AW-1) has `stop_n` low together with `trdy_n` low. If it completes with `frame_n` still low, `trdy_n` goes high while `stop_n` stays low until `frame_n` is seen high; then the release of R7 follows.
- R9: One clock after every clock with `ad_oe` high, `par_oe` is high and `par` makes the 36 bits of that clock's `ad_out` and `cbe_n`, plus `par`, even. All four `cbe_n` bits count whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; also gates all enables off at once |
| frame_n | input | 1 | Master transaction frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as sampled |
| cbe_n | input | 4 | Command / byte enables, active low |
| ad_out | output | 32 | Read data to drive on the AD lines |
| ad_oe | output | 1 | Enable for the AD drivers |
| trdy_n | output | 1 | Target ready value, active low |
| trdy_oe | output | 1 | Enable for target ready |
| stop_n | output | 1 | Stop request value, active low |
| stop_oe | output | 1 | Enable for stop |
| devsel_n | output | 1 | Device select value, active low |
| devsel_oe | output | 1 | Enable for device select |
| par | output | 1 | Even parity over the previous AD and C/BE clock |
| par_oe | output | 1 | Enable for parity |

## Verification
Every result has a fixed distance from its stimulus. Write ready and device select appear one clock after the address edge, and read data two clocks after. Parity comes one clock after each driven data clock. Release starts one clock after the final completion, and the enables drop one clock after that. The bench changes inputs on falling edges and checks outputs at the falling edge that follows the rising edge where each result is due. Every intermediate clock is checked too, so early or late responses are caught. The reset check samples one time step after `rst` rises, between edges, to confirm the enables drop without waiting for a clock.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int BUS_W = 32;
  localparam int BE_W  = BUS_W / 8;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_DATA,
    S_DISC,
    S_REL
  } bt_state_e;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          WORD_AW   = 4
) (
  input  logic [BUS_W-1:0]   ad_in,
  input  logic [3:0]         cmd,
  output logic               hit,
  output logic               is_read,
  output logic [WORD_AW-1:0] word
);
  localparam int TAG_LO = WORD_AW + 2;

  logic tag_ok;
  logic cmd_ok;

  always_comb begin
    tag_ok  = (ad_in[BUS_W-1:TAG_LO] == BASE_ADDR[BUS_W-1:TAG_LO]) && (ad_in[1:0] == 2'b00);
    cmd_ok  = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    hit     = tag_ok && cmd_ok;
    is_read = (cmd == CMD_MEM_RD);
    word    = ad_in[TAG_LO-1:2];
  end
endmodule

// File: rtl/bt_store.sv
module bt_store #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            we,
  input  logic [DW/8-1:0] be,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int WORDS = 1 << AW;
  localparam int NB    = DW / 8;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bt_parity.sv
module bt_parity
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             drive,
  input  logic [BUS_W-1:0] ad,
  input  logic [BE_W-1:0]  cbe_n,
  output logic             par,
  output logic             par_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par_oe <= drive;
      if (drive) par <= ^{ad, cbe_n};
    end
  end
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl
  import bt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int          WORD_AW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [BUS_W-1:0] ad_in,
  input  logic [BE_W-1:0]  cbe_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             trdy_n,
  output logic             trdy_oe,
  output logic             stop_n,
  output logic             stop_oe,
  output logic             devsel_n,
  output logic             devsel_oe,
  output logic             par,
  output logic             par_oe
);
  localparam logic [WORD_AW-1:0] LAST = {WORD_AW{1'b1}};
  localparam logic [WORD_AW-1:0] ONE  = {{(WORD_AW-1){1'b0}}, 1'b1};

  bt_state_e          state;
  logic [WORD_AW-1:0] idx;
  logic [WORD_AW-1:0] idx_nx;
  logic               is_rd;
  logic               frame_q;
  logic               ctl_oe_q;
  logic               ad_oe_q;
  logic               trdy_n_q;
  logic               stop_n_q;
  logic               devsel_n_q;

  logic               dec_hit;
  logic               dec_rd;
  logic [WORD_AW-1:0] dec_word;
  logic               addr_phase;
  logic               complete;
  logic [WORD_AW-1:0] rd_addr;
  logic [BUS_W-1:0]   rd_data;
  logic               par_q;
  logic               par_oe_q;

  bt_decode #(.BASE_ADDR(BASE_ADDR), .WORD_AW(WORD_AW)) u_dec (
    .ad_in   (ad_in),
    .cmd     (cbe_n),
    .hit     (dec_hit),
    .is_read (dec_rd),
    .word    (dec_word)
  );

  always_comb begin
    addr_phase = (state == S_IDLE) && !frame_n && frame_q;
    complete   = (state == S_DATA) && !irdy_n && !trdy_n_q;
    idx_nx     = idx + ONE;
    rd_addr    = complete ? idx_nx : idx;
  end

  bt_store #(.AW(WORD_AW), .DW(BUS_W)) u_mem (
    .clk     (clk),
    .we      (complete && !is_rd),
    .be      (~cbe_n),
    .wr_addr (idx),
    .wr_data (ad_in),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  bt_parity u_par (
    .clk    (clk),
    .rst    (rst),
    .drive  (ad_oe_q),
    .ad     (rd_data),
    .cbe_n  (cbe_n),
    .par    (par_q),
    .par_oe (par_oe_q)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      is_rd      <= 1'b0;
      ctl_oe_q   <= 1'b0;
      ad_oe_q    <= 1'b0;
      trdy_n_q   <= 1'b1;
      stop_n_q   <= 1'b1;
      devsel_n_q <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (addr_phase && dec_hit) begin
            idx        <= dec_word;
            is_rd      <= dec_rd;
            ctl_oe_q   <= 1'b1;
            devsel_n_q <= 1'b0;
            if (dec_rd) begin
              state    <= S_TURN;
              trdy_n_q <= 1'b1;
              stop_n_q <= 1'b1;
            end else begin
              state    <= S_DATA;
              trdy_n_q <= 1'b0;
              stop_n_q <= !(dec_word == LAST);
            end
          end
        end
        S_TURN: begin
          state    <= S_DATA;
          trdy_n_q <= 1'b0;
          ad_oe_q  <= 1'b1;
          stop_n_q <= !(idx == LAST);
        end
        S_DATA: begin
          if (complete) begin
            if (frame_n) begin
              state      <= S_REL;
              trdy_n_q   <= 1'b1;
              stop_n_q   <= 1'b1;
              devsel_n_q <= 1'b1;
              ad_oe_q    <= 1'b0;
            end else if (!stop_n_q) begin
              state    <= S_DISC;
              trdy_n_q <= 1'b1;
              ad_oe_q  <= 1'b0;
            end else begin
              idx      <= idx_nx;
              stop_n_q <= !(idx_nx == LAST);
            end
          end
        end
        S_DISC: begin
          if (frame_n) begin
            state      <= S_REL;
            stop_n_q   <= 1'b1;
            devsel_n_q <= 1'b1;
          end
        end
        S_REL: begin
          state    <= S_IDLE;
          ctl_oe_q <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ad_out    = rd_data;
  assign ad_oe     = ad_oe_q  & ~rst;
  assign trdy_n    = trdy_n_q;
  assign trdy_oe   = ctl_oe_q & ~rst;
  assign stop_n    = stop_n_q;
  assign stop_oe   = ctl_oe_q & ~rst;
  assign devsel_n  = devsel_n_q;
  assign devsel_oe = ctl_oe_q & ~rst;
  assign par       = par_q;
  assign par_oe    = par_oe_q & ~rst;

  // R3
  trdy_with_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe_q && !trdy_n_q) |-> !devsel_n_q);

  // R4
  read_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && dec_hit && dec_rd) |=> (ctl_oe_q && !ad_oe_q && trdy_n_q && !devsel_n_q));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe_q && !trdy_n_q && irdy_n) |=> $stable(rd_data));

  // R7
  last_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && !irdy_n && !trdy_n_q && frame_n)
      |=> (ctl_oe_q && trdy_n_q && stop_n_q && devsel_n_q && !ad_oe_q));

  // R8
  stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe_q && !stop_n_q) |-> (idx == LAST));

  // R9
  parity_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe_q |=> par_oe_q);
endmodule

// File: tb/sim_bus_target_ctrl.sv
module sim_bus_target_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 4;
  localparam logic [31:0] BASE       = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n, irdy_n;
  logic [31:0] ad_in;
  logic [3:0]  cbe_n;
  logic [31:0] ad_out;
  logic        ad_oe, trdy_n, trdy_oe, stop_n, stop_oe;
  logic        devsel_n, devsel_oe, par, par_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_target_ctrl #(.BASE_ADDR(BASE), .WORD_AW(AW)) u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .trdy_n(trdy_n), .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .par(par), .par_oe(par_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    ad_in   = '0;
    cbe_n   = 4'hF;
  endtask

  function automatic logic [31:0] addr_of(int i);
    return BASE + 32'(i * 4);
  endfunction

  function automatic logic [31:0] all_oe();
    return {27'b0, ad_oe, trdy_oe, stop_oe, devsel_oe, par_oe};
  endfunction

  function automatic logic [31:0] ctl_bits();
    return {26'b0, trdy_oe, trdy_n, stop_oe, stop_n, devsel_oe, devsel_n};
  endfunction

  task automatic wr_single(int i, logic [31:0] d, logic [3:0] be_n, string req);
    frame_n = 1'b0; ad_in = addr_of(i); cbe_n = 4'b0111;
    tick();
    check({req, " write ready after address"}, {30'b0, trdy_oe, trdy_n}, 32'h2);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = d; cbe_n = be_n;
    tick();
    check("R7 release drives strobes high", ctl_bits(), 32'h3F);
    bus_idle();
    tick();
    check("R7 enables dropped after release", all_oe(), 32'h0);
  endtask

  task automatic rd_single(int i, logic [3:0] be_n, logic [31:0] exp, string req);
    frame_n = 1'b0; ad_in = addr_of(i); cbe_n = 4'b0110;
    tick();
    check("R4 turnaround clock", {27'b0, devsel_oe, devsel_n, trdy_oe, trdy_n, ad_oe}, 32'h16);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = '0; cbe_n = be_n;
    tick();
    check("R4 data clock drive", {30'b0, ad_oe, trdy_n}, 32'h2);
    check({req, " read data"}, ad_out, exp);
    tick();
    check("R9 parity valid", {30'b0, par_oe, par}, {30'b0, 1'b1, ^{exp, be_n}});
    check("R7 read release", ctl_bits(), 32'h3F);
    bus_idle();
    tick();
    check("R7 read released", all_oe(), 32'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1; bus_idle();
    repeat (3) tick();
    check("R1 enables low in reset", all_oe(), 32'h0);
    rst = 1'b0;
    tick();
    check("R1 enables low after reset", all_oe(), 32'h0);
  endtask

  task automatic t_bytes();
    wr_single(2, 32'hAABB_CCDD, 4'b0000, "R3");
    wr_single(2, 32'h1122_3344, 4'b1010, "R3");
    rd_single(2, 4'b0000, 32'hAA22_CC44, "R3 byte enables");
    rd_single(2, 4'b1010, 32'hAA22_CC44, "R9 disabled-byte parity");
  endtask

  task automatic t_burst();
    logic [31:0] d [3] = '{32'h0101_0101, 32'h2345_6789, 32'hFEDC_BA98};
    frame_n = 1'b0; ad_in = addr_of(3); cbe_n = 4'b0111;
    tick();
    for (int k = 0; k < 3; k++) begin
      irdy_n = 1'b0; ad_in = d[k]; cbe_n = 4'b0000; frame_n = (k == 2);
      tick();
    end
    check("R7 burst write release", ctl_bits(), 32'h3F);
    bus_idle(); tick();
    frame_n = 1'b0; ad_in = addr_of(3); cbe_n = 4'b0110;
    tick();
    irdy_n = 1'b1; ad_in = '0; cbe_n = 4'b0000;
    tick();
    check("R6 burst word 0", ad_out, d[0]);
    tick();
    check("R5 wait holds data", ad_out, d[0]);
    check("R5 wait keeps ready", {30'b0, ad_oe, trdy_n}, 32'h2);
    irdy_n = 1'b0;
    tick();
    check("R6 burst word 1", ad_out, d[1]);
    tick();
    check("R6 burst word 2", ad_out, d[2]);
    frame_n = 1'b1;
    tick();
    check("R7 burst read release", ctl_bits(), 32'h3F);
    bus_idle(); tick();
    check("R7 burst read released", all_oe(), 32'h0);
  endtask

  task automatic t_stop();
    wr_single(14, 32'h1414_1414, 4'b0000, "R3");
    wr_single(15, 32'h1515_1515, 4'b0000, "R3");
    frame_n = 1'b0; ad_in = addr_of(14); cbe_n = 4'b0110;
    tick();
    irdy_n = 1'b0; ad_in = '0; cbe_n = 4'b0000;
    tick();
    check("R8 no stop before last word", {30'b0, stop_n, trdy_n}, 32'h2);
    tick();
    check("R8 last word data", ad_out, 32'h1515_1515);
    check("R8 stop with ready on last word", {30'b0, stop_n, trdy_n}, 32'h0);
    tick();
    check("R8 disconnect holds stop", {29'b0, stop_n, trdy_n, devsel_n}, 32'h2);
    frame_n = 1'b1;
    tick();
    check("R8 release after frame high", ctl_bits(), 32'h3F);
    bus_idle(); tick();
    check("R8 released", all_oe(), 32'h0);
  endtask

  task automatic t_miss();
    wr_single(0, 32'h0BAD_F00D, 4'b0000, "R3");
    frame_n = 1'b0; ad_in = addr_of(0); cbe_n = 4'b0011;
    tick();
    check("R2 wrong command not claimed", all_oe(), 32'h0);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'b0000;
    tick();
    check("R2 wrong command no ready", all_oe(), 32'h0);
    bus_idle(); tick();
    frame_n = 1'b0; ad_in = BASE + 32'h100; cbe_n = 4'b0111;
    tick();
    check("R2 outside window not claimed", all_oe(), 32'h0);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'b0000;
    tick();
    bus_idle(); tick();
    rd_single(0, 4'b0000, 32'h0BAD_F00D, "R2 store untouched");
  endtask

  task automatic t_reset_mid();
    frame_n = 1'b0; ad_in = addr_of(7); cbe_n = 4'b0111;
    tick();
    check("R1 write claimed before reset", {31'b0, trdy_oe}, 32'h1);
    rst = 1'b1;
    #1;
    check("R1 enables drop with reset", all_oe(), 32'h0);
    tick(); tick();
    bus_idle(); rst = 1'b0;
    tick();
    check("R1 enables stay low after reset", all_oe(), 32'h0);
  endtask

  initial begin
    t_reset();
    t_bytes();
    t_burst();
    t_stop();
    t_miss();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1..R9 actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule